// File: doc/BRIEF.md
# PCI Type-0 Configuration Header

This block holds the standard type-0 configuration header of a single PCI function and serves it through a narrow register port. A request names a dword of the header and a byte-enable pattern selecting a 1-, 2- or 4-byte access. Reads return the selected lanes, and writes update the fields that accept them. Each request gets a response one cycle later: the read data and an error flag.

The writable fields are command, cache line size, latency timer, interrupt line, six base address registers and the expansion ROM base. Each BAR has a power-of-two window size fixed by a parameter, and an I/O-or-memory type also fixed by a parameter. The BAR answers the size probe, where all ones are written and the value is read back. Identity and descriptive fields are constants. Some of them silently drop writes. For the others, a write is refused with the error flag. Accesses past the header, into the device-specific area, are always refused.

Top module: `pci_cfg_header`

## Requirements
- R1: Legal byte-enable patterns are 0001, 0010, 0100, 1000, 0011, 1100 and 1111. Any other pattern, including 0000, sets the error flag and changes no state.
- R2: Any access with dword index 16 or above (byte offset 0x40 and up) sets the error flag, returns zero data and changes no state.
- R3: A request in one cycle produces `rsp_vld` in the next cycle, and an idle cycle produces no response. Read lanes whose byte enable is clear return zero, and an errored response returns zero data.
- R4: A BAR with window size S stores only write-data bits at positions log2(S) and above. Bits between the type bits and log2(S) read zero, so writing all ones reads back ~(S-1) combined with the type bits.
- R5: The type bits of a BAR keep their reset value whatever is written: an I/O BAR reads 01 in bits [1:0], and a memory BAR reads 0000 in bits [3:0].
- R6: A BAR whose size parameter is zero always reads zero. A write to it is accepted without error and has no effect.
- R7: BAR dwords (4 to 9) and the ROM dword (12) accept only 4-byte writes. A partial write sets the error flag and changes nothing.
- R8: Writing 0xFFFFFFFE to the ROM base register (dword 12) makes it read 0xFFFFFFFF. Any other value reads back exactly as written.
- R9: Command (dword 1, bytes 0-1), cache line size (dword 3, byte 0), latency timer (dword 3, byte 1) and interrupt line (dword 15, byte 0) take writes. Each byte changes only when its own enable is set.
- R10: Writes to status (dword 1, bytes 2-3), revision and class code (dword 2), and interrupt pin, min grant and max latency (dword 15, bytes 1-3) are accepted without error and have no effect.
- R11: A write whose enabled bytes touch a refused location sets the error flag, and the whole write is dropped, including any writable bytes in it. The refused locations are dwords 0, 10, 11, 13 and 14, and dword 3 bytes 2-3.
- R12: Dwords read little-endian with these layouts: dword 0 = {device ID, vendor ID}, dword 2 = {class code, revision}, dword 3 = {BIST 0, header type 0, latency, cache line}, dword 11 = {subsystem ID, subsystem vendor}, dword 15 = {max latency, min grant, interrupt pin, interrupt line}.
- R13: After reset, command, status, cache line, latency, interrupt line, ROM base and all BAR address bits read zero. The BAR type bits read their fixed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| dw | input | 6 | Dword index (byte offset / 4) |
| be | input | 4 | Byte enables, bit n = byte lane n |
| wdata | input | 32 | Write data, little-endian lanes |
| rsp_vld | output | 1 | Response valid, one cycle after req |
| rdata | output | 32 | Read data, zero in disabled lanes |
| err | output | 1 | Access refused |

## Verification
Directed probes of BARs of every kind tell window masking apart from type protection: a memory BAR, an I/O BAR and a zero-size BAR each get all ones, zero and an arbitrary value. Mixed writes that cover both a writable byte and a refused or ignored byte separate the rule that drops the whole write from the rule that drops a single lane. Random traffic over legal and illegal enable patterns and over dwords inside and beyond the header is checked against a bench model. This catches lane spill between neighbouring fields, wrong refusal decisions, and any ROM probe value other than exactly 0xFFFFFFFE.

// File: rtl/pci_cfg_header.sv
module pci_cfg_header #(
  parameter logic [15:0] VENDOR_ID  = 16'h1D0F,
  parameter logic [15:0] DEVICE_ID  = 16'h7A21,
  parameter logic [15:0] SUBSYS_VID = 16'h1D0F,
  parameter logic [15:0] SUBSYS_ID  = 16'h0003,
  parameter logic [7:0]  REV_ID     = 8'h02,
  parameter logic [23:0] CLASS_CODE = 24'h020000,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter logic [7:0]  MIN_GNT    = 8'h04,
  parameter logic [7:0]  MAX_LAT    = 8'h10,
  parameter logic [5:0]  BAR_IO     = 6'b000010,
  parameter logic [35:0] BAR_LOG2   = {6'd0, 6'd0, 6'd20, 6'd0, 6'd8, 6'd12}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        wr,
  input  logic [5:0]  dw,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic        rsp_vld,
  output logic [31:0] rdata,
  output logic        err
);
  localparam int NBAR   = 6;
  localparam int HDR_DW = 16;
  localparam int BAR_DW = 4;
  localparam int ROM_DW = 12;

  logic [15:0] cmd_q;
  logic [7:0]  cls_q, lat_q, il_q;
  logic [31:0] rom_q;
  logic [31:0] bar_rd [NBAR];
  logic [3:0]  fb;
  logic [31:0] rd_word;

  wire be_ok   = (be == 4'b0001) || (be == 4'b0010) || (be == 4'b0100) || (be == 4'b1000) ||
                 (be == 4'b0011) || (be == 4'b1100) || (be == 4'b1111);
  wire in_hdr  = dw < 6'(HDR_DW);
  wire is_bar  = (dw >= 6'(BAR_DW)) && (dw < 6'(BAR_DW + NBAR));
  wire need_fw = is_bar || (dw == 6'(ROM_DW));

  always_comb begin
    case (dw)
      6'd0, 6'd10, 6'd11, 6'd13, 6'd14: fb = 4'b1111;
      6'd3:                             fb = 4'b1100;
      default:                          fb = 4'b0000;
    endcase
  end

  wire bad = !be_ok || !in_hdr || (wr && ((|(be & fb)) || (need_fw && be != 4'b1111)));
  wire wok = req && wr && !bad;

  for (genvar i = 0; i < NBAR; i++) begin : g_bar
    localparam int   LG    = int'(BAR_LOG2[6*i +: 6]);
    localparam bit   IO    = BAR_IO[i];
    localparam int   LOWB  = IO ? 2 : 4;
    localparam int   EFF   = (LG < LOWB) ? LOWB : ((LG > 31) ? 31 : LG);
    localparam logic [31:0] AMASK = (LG == 0) ? 32'd0 : ~((32'd1 << EFF) - 32'd1);
    localparam logic [31:0] TYPEB = (LG == 0) ? 32'd0 : {31'd0, IO};
    logic [31:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                            q <= '0;
      else if (wok && dw == 6'(BAR_DW + i))  q <= wdata & AMASK;
    end
    assign bar_rd[i] = (q & AMASK) | TYPEB;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      cls_q <= '0;
      lat_q <= '0;
      il_q  <= '0;
      rom_q <= '0;
    end else if (wok) begin
      if (dw == 6'd1) begin
        if (be[0]) cmd_q[7:0]  <= wdata[7:0];
        if (be[1]) cmd_q[15:8] <= wdata[15:8];
      end
      if (dw == 6'd3) begin
        if (be[0]) cls_q <= wdata[7:0];
        if (be[1]) lat_q <= wdata[15:8];
      end
      if (dw == 6'd15 && be[0]) il_q <= wdata[7:0];
      if (dw == 6'(ROM_DW))
        rom_q <= (wdata == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : wdata;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NBAR; i++)
      if (dw == 6'(BAR_DW + i)) rd_word = bar_rd[i];
    case (dw)
      6'd0:    rd_word = {DEVICE_ID, VENDOR_ID};
      6'd1:    rd_word = {16'h0000, cmd_q};
      6'd2:    rd_word = {CLASS_CODE, REV_ID};
      6'd3:    rd_word = {16'h0000, lat_q, cls_q};
      6'd11:   rd_word = {SUBSYS_ID, SUBSYS_VID};
      6'd12:   rd_word = rom_q;
      6'd15:   rd_word = {MAX_LAT, MIN_GNT, INT_PIN, il_q};
      default: ;
    endcase
  end

  wire [31:0] lanes = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld <= 1'b0;
      rdata   <= '0;
      err     <= 1'b0;
    end else begin
      rsp_vld <= req;
      err     <= req && bad;
      rdata   <= (req && !wr && !bad) ? (rd_word & lanes) : 32'd0;
    end
  end
endmodule

module pci_cfg_header_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        wr,
  input logic [5:0]  dw,
  input logic [3:0]  be,
  input logic [31:0] wdata,
  input logic        rsp_vld,
  input logic [31:0] rdata,
  input logic        err,
  input logic [15:0] cmd_q,
  input logic [31:0] rom_q
);
  wire legal_be = (be == 4'b0001) || (be == 4'b0010) || (be == 4'b0100) || (be == 4'b1000) ||
                  (be == 4'b0011) || (be == 4'b1100) || (be == 4'b1111);

  p_badbe_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req && !legal_be |=> err);
  p_high_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req && dw >= 6'd16 |=> err && rdata == 32'd0);
  p_high_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req && wr && dw >= 6'd16 |=> $stable(cmd_q) && $stable(rom_q));
  p_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rsp_vld);
  p_norsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !rsp_vld);
  p_err_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld && err |-> rdata == 32'd0);
  p_lane_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req && !wr && !be[3] |=> rdata[31:24] == 8'd0);
  p_rom_probe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req && wr && dw == 6'd12 && be == 4'b1111 && wdata == 32'hFFFF_FFFE |=> rom_q == 32'hFFFF_FFFF);
  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && wr && dw == 6'd1) |=> $stable(cmd_q));
endmodule

bind pci_cfg_header pci_cfg_header_chk u_chk (.*);

// File: tb/sim_pci_cfg_header.sv
module sim_pci_cfg_header;
  localparam int CLK_PERIOD = 10;
  localparam int NRAND = 1500;
  localparam logic [5:0] B_IO = 6'b000010;
  localparam int B_LOG [6] = '{12, 8, 0, 20, 0, 0};

  logic clk = 0, rst_n = 0, req = 0, wr = 0;
  logic [5:0] dw = 0;
  logic [3:0] be = 0;
  logic [31:0] wdata = 0;
  logic rsp_vld, err;
  logic [31:0] rdata;
  int total = 0, fails = 0;
  bit done = 0;

  logic [15:0] m_cmd;
  logic [7:0] m_cls, m_lat, m_il;
  logic [31:0] m_rom;
  logic [31:0] m_bar [6];

  pci_cfg_header u0 (.clk, .rst_n, .req, .wr, .dw, .be, .wdata, .rsp_vld, .rdata, .err);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] amask(int i);
    int lg = B_LOG[i];
    int lo = B_IO[i] ? 2 : 4;
    if (lg == 0) return 32'd0;
    if (lg < lo) lg = lo;
    return ~((32'd1 << lg) - 32'd1);
  endfunction

  function automatic logic [31:0] tbits(int i);
    return (B_LOG[i] == 0) ? 32'd0 : {31'd0, B_IO[i]};
  endfunction

  function automatic bit legal(logic [3:0] b);
    return b inside {4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100, 4'b1111};
  endfunction

  function automatic bit m_err(bit w, logic [5:0] d, logic [3:0] b);
    logic [3:0] f;
    if (!legal(b) || d >= 16) return 1;
    if (!w) return 0;
    f = (d inside {0, 10, 11, 13, 14}) ? 4'hF : (d == 3) ? 4'hC : 4'h0;
    if (|(b & f)) return 1;
    if ((d inside {[4:9]} || d == 12) && b != 4'hF) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] m_word(logic [5:0] d);
    case (d)
      0: return {16'h7A21, 16'h1D0F};
      1: return {16'h0, m_cmd};
      2: return {24'h020000, 8'h02};
      3: return {16'h0, m_lat, m_cls};
      4, 5, 6, 7, 8, 9: return m_bar[d-4] | tbits(d-4);
      11: return {16'h0003, 16'h1D0F};
      12: return m_rom;
      15: return {8'h10, 8'h04, 8'h01, m_il};
      default: return 32'd0;
    endcase
  endfunction

  task automatic m_reset();
    m_cmd = 0; m_cls = 0; m_lat = 0; m_il = 0; m_rom = 0;
    for (int i = 0; i < 6; i++) m_bar[i] = 0;
  endtask

  task automatic m_apply(logic [5:0] d, logic [3:0] b, logic [31:0] v);
    if (d == 1) begin
      if (b[0]) m_cmd[7:0] = v[7:0];
      if (b[1]) m_cmd[15:8] = v[15:8];
    end
    if (d == 3) begin
      if (b[0]) m_cls = v[7:0];
      if (b[1]) m_lat = v[15:8];
    end
    if (d == 15 && b[0]) m_il = v[7:0];
    if (d >= 4 && d <= 9) m_bar[d-4] = v & amask(d-4);
    if (d == 12) m_rom = (v == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : v;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(bit w, logic [5:0] d, logic [3:0] b, logic [31:0] v, string tag);
    bit e = m_err(w, d, b);
    logic [31:0] lanes = {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
    logic [31:0] er = (!w && !e) ? (m_word(d) & lanes) : 32'd0;
    @(negedge clk);
    req = 1; wr = w; dw = d; be = b; wdata = v;
    @(negedge clk);
    req = 0;
    if (w && !e) m_apply(d, b, v);
    check({tag, " rsp_vld"}, {31'd0, rsp_vld}, 32'd1);
    check({tag, " err"}, {31'd0, err}, {31'd0, e});
    check({tag, " rdata"}, rdata, er);
  endtask

  task automatic rd(logic [5:0] d, string tag);
    op(0, d, 4'hF, 32'd0, tag);
  endtask

  function automatic string rtag(bit w, logic [5:0] d, logic [3:0] b);
    if (!legal(b)) return "R1";
    if (d >= 16) return "R2";
    if (!w) return "R12";
    if (d >= 4 && d <= 9) return (b != 4'hF) ? "R7" : "R4";
    if (d == 12) return "R8";
    if (d inside {0, 10, 11, 13, 14} || (d == 3 && b[3:2] != 0)) return "R11";
    if (d == 2) return "R10";
    return "R9";
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; total++;
      $display("FAIL R3 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int unsigned seed = $urandom(32'd20240611);
    logic [3:0] bes [10] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011,
                             4'b1100, 4'b1111, 4'b0101, 4'b0110, 4'b0000};
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R3 idle", {31'd0, rsp_vld}, 32'd0);
    for (int d = 0; d < 16; d++) rd(6'(d), "R13 R12 reset");

    op(1, 4, 4'hF, 32'hFFFF_FFFF, "R4 probe");
    rd(4, "R4 mem probe ~(4K-1)");
    op(1, 4, 4'hF, 32'h1234_5678, "R4 addr");
    rd(4, "R4 low bits dropped");
    op(1, 7, 4'hF, 32'hFFFF_FFFF, "R4 probe big");
    rd(7, "R4 1M probe");
    op(1, 5, 4'hF, 32'h0000_0000, "R5 io zero");
    rd(5, "R5 io type kept");
    op(1, 5, 4'hF, 32'hFFFF_FFFF, "R5 io probe");
    rd(5, "R5 io probe type");
    op(1, 4, 4'hF, 32'h0000_000F, "R5 mem lowbits");
    rd(4, "R5 mem type");
    op(1, 6, 4'hF, 32'hFFFF_FFFF, "R6 zero bar write");
    rd(6, "R6 zero bar reads 0");
    op(1, 4, 4'b0011, 32'hAAAA_5555, "R7 partial bar");
    rd(4, "R7 bar unchanged");
    op(1, 12, 4'b1100, 32'h1111_0000, "R7 partial rom");
    op(1, 12, 4'hF, 32'hFFFF_FFFE, "R8 rom probe");
    rd(12, "R8 rom reads ones");
    op(1, 12, 4'hF, 32'hABCD_0001, "R8 rom store");
    rd(12, "R8 rom value");
    op(1, 3, 4'b0001, 32'h0000_0020, "R9 cls");
    op(1, 3, 4'b0010, 32'h0000_4000, "R9 lat only");
    rd(3, "R9 no spill");
    op(1, 1, 4'b0011, 32'hFFFF_0107, "R9 command");
    rd(1, "R9 cmd R10 status zero");
    op(1, 15, 4'b1111, 32'hEEEE_EE0B, "R10 int pin ignored");
    rd(15, "R10 R9 dword15");
    op(1, 2, 4'hF, 32'h1234_5678, "R10 class");
    rd(2, "R10 class unchanged");
    op(1, 0, 4'b0001, 32'h0000_0099, "R11 id");
    op(1, 3, 4'hF, 32'hFFFF_7777, "R11 whole drop");
    rd(3, "R11 cls lat kept");
    op(1, 13, 4'b0001, 32'h1, "R11 cap");
    op(0, 16, 4'hF, 32'd0, "R2 read high");
    op(1, 40, 4'hF, 32'hFFFF_FFFF, "R2 write high");
    op(1, 1, 4'b0101, 32'hFFFF_FFFF, "R1 be 0101");
    op(0, 1, 4'b0110, 32'd0, "R1 be 0110");
    op(0, 0, 4'b0000, 32'd0, "R1 be 0000");
    op(0, 0, 4'b0100, 32'd0, "R3 lane select");
    op(0, 11, 4'b1100, 32'd0, "R12 upper half");

    for (int n = 0; n < NRAND; n++) begin
      bit w = $urandom_range(0, 1);
      logic [5:0] d = 6'($urandom_range(0, 19));
      logic [3:0] b = ($urandom_range(0, 5) == 0) ? bes[$urandom_range(7, 9)] : bes[$urandom_range(0, 6)];
      int k = $urandom_range(0, 7);
      logic [31:0] v = (k == 0) ? 32'hFFFF_FFFF : (k == 1) ? 32'hFFFF_FFFE : $urandom;
      if (d inside {[4:9], 12} && w && $urandom_range(0, 1)) b = 4'hF;
      op(w, d, b, v, rtag(w, d, b));
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule